// File: doc/BRIEF.md
# Interrupt Sample, Poll and Vector Sequencer

This block decides when a small microcontroller core takes an interrupt. The core's machine cycle has six states of two phases each. The core reports the current state and phase on every clock, and each clock is one phase. The block latches six interrupt sources into eight request flags at fixed points in that cycle: two active-low external pins, overflow flags from timers 0 and 1, receive and transmit flags from a serial port, and overflow and external flags from timer 2. It polls those flags once per machine cycle.

When a polled request is eligible and the core allows acceptance, the block asks for a hardware call. The call request lasts exactly two machine cycles and carries a source index and a priority bit. This makes the response latency exact to the cycle. A request latched at the late latch point waits one full machine cycle before polling. It then takes two call cycles, so at least three whole machine cycles pass before the service routine starts.

The core supplies the in-service priority levels, a "last cycle of instruction" flag and a "blocking instruction" flag. A blocking instruction is a return-from-interrupt or a write to the enable or priority register. The core executes the call itself.

Top module: `int_sample_seq`

## Requirements
- R1: State encoding is `cyc_state` = 1..6 and `cyc_phase` = 0 for P1 or 1 for P2. For an external channel in level mode (`ext_edge[k]`=0), the flag takes the inverted pin level at the clock edge that ends state 5 phase 2. Channel 0 uses flag bit 0 and channel 1 uses flag bit 2.
- R2: For an external channel in edge mode (`ext_edge[k]`=1), the flag is set at the state 5 phase 2 edge when the pin is low and was high at the previous such sample. The pin sample history resets to high.
- R3: Flag bit positions are tmr0 = bit 1, tmr1 = bit 3, serial rx = bit 4, serial tx = bit 5, tmr2 external = bit 7 and tmr2 overflow = bit 6. The first five are set only when their set input is high during state 5 phase 2. The tmr2 overflow flag is set only when its input is high during state 2 phase 2. A set input at any other phase has no effect.
- R4: Polling happens at the state 4 phase 2 edge and uses the flag values held before that edge. A flag latched at state 5 phase 2 is therefore first polled in the next machine cycle. The tmr2 overflow flag is polled in the machine cycle in which it was set.
- R5: Source indices are 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial (rx or tx), and 5 tmr2 (overflow or external). Among eligible sources, those with `src_hi` set win over the others, and within a level the lower index wins.
- R6: A request is accepted only when `insn_last`=1 and `insn_block`=0 at the poll, and no accepted call is pending or running.
- R7: `svc_hi`=1 blocks every source. `svc_lo`=1 blocks the sources whose `src_hi` bit is 0.
- R8: After acceptance, `call_req` rises at the state 6 phase 2 edge of the accepting cycle and stays high for exactly two machine cycles. `call_src` and `call_hi` hold the accepted source and level for that whole time.
- R9: When a call begins, its flag is cleared by hardware if it belongs to an edge-mode external channel or to tmr0 or tmr1. Serial and tmr2 flags are left set.
- R10: A high `sw_clr` bit clears the matching flag at that edge. A set at the same edge wins.
- R11: A source whose `src_en` bit is 0 is never selected, and its flag is kept.
- R12: Reset clears all flags, drops `call_req` and ends any pending acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per phase |
| rst | input | 1 | Synchronous active-high reset |
| cyc_state | input | 3 | Current machine state, 1..6 |
| cyc_phase | input | 1 | Current phase, 0 = P1, 1 = P2 |
| ext_n | input | 2 | Active-low external interrupt pins |
| ext_edge | input | 2 | Per-channel edge (1) or level (0) mode |
| tmr0_ovf | input | 1 | Timer 0 overflow set input |
| tmr1_ovf | input | 1 | Timer 1 overflow set input |
| ser_rx_set | input | 1 | Serial receive flag set input |
| ser_tx_set | input | 1 | Serial transmit flag set input |
| tmr2_ovf | input | 1 | Timer 2 overflow set input |
| tmr2_ext | input | 1 | Timer 2 external flag set input |
| src_en | input | 6 | Per-source enable |
| src_hi | input | 6 | Per-source high priority select |
| svc_lo | input | 1 | A low-priority routine is in service |
| svc_hi | input | 1 | A high-priority routine is in service |
| insn_last | input | 1 | Current machine cycle ends an instruction |
| insn_block | input | 1 | Current instruction blocks acceptance |
| sw_clr | input | 8 | Software flag clear, one bit per flag |
| req_flags | output | 8 | Latched request flags |
| call_req | output | 1 | Hardware call in progress |
| call_src | output | 3 | Source index of the call |
| call_hi | output | 1 | Priority level of the call |

## Verification
The bench drives a set input at a phase other than its latch point. A block that latched such a pulse would show a stray flag and a call that is not expected. It times the tmr2 overflow flag, which is polled in its own machine cycle, against a timer 0 flag, which must wait a cycle; polling both at the same point would shift one call by twelve clocks. It arms several sources in one cycle under mixed priority levels and then allows acceptance. A wrong order, or a flag that is not cleared or wrongly cleared at call start, shows up as a changed call sequence. Gating by the last instruction cycle, by blocking instructions, by in-service levels and by disabled sources is held for several cycles to show that no call starts early.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;

    localparam int N_FLAG = 8;
    localparam int N_SRC  = 6;
    localparam int SRC_W  = 3;

    // flag bit positions
    localparam int FL_EXT0  = 0;
    localparam int FL_TMR0  = 1;
    localparam int FL_EXT1  = 2;
    localparam int FL_TMR1  = 3;
    localparam int FL_RX    = 4;
    localparam int FL_TX    = 5;
    localparam int FL_T2OVF = 6;
    localparam int FL_T2EXT = 7;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;

    typedef struct packed {
        logic [2:0] st;
        logic       ph;
    } slot_t;

    typedef struct packed {
        logic vld;
        logic hi;
        src_e src;
    } pick_t;

    function automatic logic at_slot(slot_t s, logic [2:0] st);
        return (s.st == st) && s.ph;
    endfunction

    function automatic int ext_pos(int k);
        return (k == 0) ? FL_EXT0 : FL_EXT1;
    endfunction

    // fold the eight flags into six sources
    function automatic logic [N_SRC-1:0] src_req(logic [N_FLAG-1:0] f);
        logic [N_SRC-1:0] r;
        r[SRC_EXT0] = f[FL_EXT0];
        r[SRC_TMR0] = f[FL_TMR0];
        r[SRC_EXT1] = f[FL_EXT1];
        r[SRC_TMR1] = f[FL_TMR1];
        r[SRC_SER]  = f[FL_RX] | f[FL_TX];
        r[SRC_TMR2] = f[FL_T2OVF] | f[FL_T2EXT];
        return r;
    endfunction

endpackage

// File: rtl/int_flag_bank.sv
module int_flag_bank
    import int_seq_pkg::*;
#(
    parameter logic [2:0] LATCH_STATE = 3'd5,
    parameter logic [2:0] T2_STATE    = 3'd2,
    parameter int         N_EXT       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slot,
    input  logic [N_EXT-1:0]  ext_n,
    input  logic [N_EXT-1:0]  ext_edge,
    input  logic              set_t0,
    input  logic              set_t1,
    input  logic              set_rx,
    input  logic              set_tx,
    input  logic              set_t2o,
    input  logic              set_t2x,
    input  logic [N_FLAG-1:0] sw_clr,
    input  logic [N_FLAG-1:0] hw_clr,
    output logic [N_FLAG-1:0] flags
);

    logic [N_FLAG-1:0] flags_q, flags_d;
    logic [N_EXT-1:0]  pin_last_q;
    logic              at_late, at_early;

    assign at_late  = at_slot(slot, LATCH_STATE);
    assign at_early = at_slot(slot, T2_STATE);

    always_comb begin
        flags_d = flags_q & ~sw_clr & ~hw_clr;
        if (at_late) begin
            for (int k = 0; k < N_EXT; k++) begin
                if (ext_edge[k]) begin
                    if (pin_last_q[k] && !ext_n[k])
                        flags_d[ext_pos(k)] = 1'b1;
                end else begin
                    flags_d[ext_pos(k)] = ~ext_n[k];
                end
            end
            flags_d[FL_TMR0]  = flags_d[FL_TMR0]  | set_t0;
            flags_d[FL_TMR1]  = flags_d[FL_TMR1]  | set_t1;
            flags_d[FL_RX]    = flags_d[FL_RX]    | set_rx;
            flags_d[FL_TX]    = flags_d[FL_TX]    | set_tx;
            flags_d[FL_T2EXT] = flags_d[FL_T2EXT] | set_t2x;
        end
        if (at_early)
            flags_d[FL_T2OVF] = flags_d[FL_T2OVF] | set_t2o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            pin_last_q <= '1;
        end else begin
            flags_q <= flags_d;
            if (at_late)
                pin_last_q <= ext_n;
        end
    end

    assign flags = flags_q;

    AST_TMR0_LATE_POINT: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[FL_TMR0]) |-> $past(at_late)); // R3
    AST_T2OVF_EARLY_POINT: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[FL_T2OVF]) |-> $past(at_early)); // R3
    AST_EXT_EDGE_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags_q[FL_EXT0]) && ext_edge[0] && $stable(ext_edge[0])) |-> $past(!ext_n[0])); // R2

endmodule

// File: rtl/int_poll_arb.sv
module int_poll_arb
    import int_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FLAG-1:0] flags,
    input  logic [N_SRC-1:0]  src_en,
    input  logic [N_SRC-1:0]  src_hi,
    input  logic              svc_lo,
    input  logic              svc_hi,
    output pick_t             pick
);

    logic [N_SRC-1:0] req, hi_req, lo_req;
    logic [SRC_W-1:0] hi_idx, lo_idx;

    assign req    = src_req(flags) & src_en;
    assign hi_req = req &  src_hi & {N_SRC{~svc_hi}};
    assign lo_req = req & ~src_hi & {N_SRC{~svc_hi & ~svc_lo}};

    // lowest index wins within a level
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hi_req[i]) hi_idx = i[SRC_W-1:0];
            if (lo_req[i]) lo_idx = i[SRC_W-1:0];
        end
    end

    always_comb begin
        pick.vld = |hi_req || |lo_req;
        pick.hi  = |hi_req;
        pick.src = src_e'((|hi_req) ? hi_idx : lo_idx);
    end

    AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (rst)
        pick.vld |-> src_en[pick.src]); // R11
    AST_HI_SVC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        svc_hi |-> !pick.vld); // R7
    AST_LO_SVC_ONLY_HI: assert property (@(posedge clk) disable iff (rst)
        (svc_lo && pick.vld) |-> (pick.hi && src_hi[pick.src])); // R7

endmodule

// File: rtl/int_call_seq.sv
module int_call_seq
    import int_seq_pkg::*;
#(
    parameter logic [2:0] POLL_STATE  = 3'd4,
    parameter logic [2:0] LAST_STATE  = 3'd6,
    parameter int         CALL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slot,
    input  pick_t             pick,
    input  logic              insn_last,
    input  logic              insn_block,
    input  logic [1:0]        ext_edge,
    output logic [N_FLAG-1:0] hw_clr,
    output logic              call_req,
    output src_e              call_src,
    output logic              call_hi
);

    localparam int LEFT_W = (CALL_CYCLES > 1) ? $clog2(CALL_CYCLES) : 1;

    logic              poll_pt, end_pt, acc_ok;
    logic              acc_pend_q;
    src_e              held_src_q;
    logic              held_hi_q;
    logic [LEFT_W-1:0] left_q;

    assign poll_pt = at_slot(slot, POLL_STATE);
    assign end_pt  = at_slot(slot, LAST_STATE);
    assign acc_ok  = poll_pt && pick.vld && insn_last && !insn_block
                     && !acc_pend_q && !call_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_pend_q <= 1'b0;
            held_src_q <= SRC_EXT0;
            held_hi_q  <= 1'b0;
            call_req   <= 1'b0;
            call_src   <= SRC_EXT0;
            call_hi    <= 1'b0;
            left_q     <= '0;
        end else begin
            if (acc_ok) begin
                acc_pend_q <= 1'b1;
                held_src_q <= pick.src;
                held_hi_q  <= pick.hi;
            end
            if (end_pt) begin
                if (acc_pend_q) begin
                    acc_pend_q <= 1'b0;
                    call_req   <= 1'b1;
                    call_src   <= held_src_q;
                    call_hi    <= held_hi_q;
                    left_q     <= LEFT_W'(CALL_CYCLES - 1);
                end else if (call_req) begin
                    if (left_q == '0)
                        call_req <= 1'b0;
                    else
                        left_q <= left_q - 1'b1;
                end
            end
        end
    end

    // flags consumed by the call start
    always_comb begin
        hw_clr = '0;
        if (end_pt && acc_pend_q) begin
            unique case (held_src_q)
                SRC_EXT0: hw_clr[FL_EXT0] = ext_edge[0];
                SRC_TMR0: hw_clr[FL_TMR0] = 1'b1;
                SRC_EXT1: hw_clr[FL_EXT1] = ext_edge[1];
                SRC_TMR1: hw_clr[FL_TMR1] = 1'b1;
                default:  hw_clr          = '0;
            endcase
        end
    end

    AST_CALL_ENDS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $fell(call_req) |-> $past(end_pt)); // R8
    AST_CALL_STARTS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(call_req) |-> $past(end_pt && acc_pend_q)); // R8
    AST_CALL_SRC_HELD: assert property (@(posedge clk) disable iff (rst)
        (call_req && $past(call_req)) |-> ($stable(call_src) && $stable(call_hi))); // R8
    AST_NO_ACCEPT_IN_CALL: assert property (@(posedge clk) disable iff (rst)
        call_req |-> !acc_pend_q); // R6
    AST_ACCEPT_NEEDS_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_pend_q) |-> $past(insn_last && !insn_block)); // R6

endmodule

// File: rtl/int_sample_seq.sv
module int_sample_seq
    import int_seq_pkg::*;
#(
    parameter logic [2:0] LATCH_STATE = 3'd5,
    parameter logic [2:0] T2_STATE    = 3'd2,
    parameter logic [2:0] POLL_STATE  = 3'd4,
    parameter logic [2:0] LAST_STATE  = 3'd6,
    parameter int         CALL_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cyc_state,
    input  logic       cyc_phase,
    input  logic [1:0] ext_n,
    input  logic [1:0] ext_edge,
    input  logic       tmr0_ovf,
    input  logic       tmr1_ovf,
    input  logic       ser_rx_set,
    input  logic       ser_tx_set,
    input  logic       tmr2_ovf,
    input  logic       tmr2_ext,
    input  logic [5:0] src_en,
    input  logic [5:0] src_hi,
    input  logic       svc_lo,
    input  logic       svc_hi,
    input  logic       insn_last,
    input  logic       insn_block,
    input  logic [7:0] sw_clr,
    output logic [7:0] req_flags,
    output logic       call_req,
    output logic [2:0] call_src,
    output logic       call_hi
);

    slot_t             slot;
    pick_t             pick;
    logic [N_FLAG-1:0] flags, hw_clr;
    src_e              call_src_e;

    assign slot.st = cyc_state;
    assign slot.ph = cyc_phase;

    int_flag_bank #(
        .LATCH_STATE (LATCH_STATE),
        .T2_STATE    (T2_STATE),
        .N_EXT       (2)
    ) i_flags (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot),
        .ext_n    (ext_n),
        .ext_edge (ext_edge),
        .set_t0   (tmr0_ovf),
        .set_t1   (tmr1_ovf),
        .set_rx   (ser_rx_set),
        .set_tx   (ser_tx_set),
        .set_t2o  (tmr2_ovf),
        .set_t2x  (tmr2_ext),
        .sw_clr   (sw_clr),
        .hw_clr   (hw_clr),
        .flags    (flags)
    );

    int_poll_arb i_arb (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .src_en (src_en),
        .src_hi (src_hi),
        .svc_lo (svc_lo),
        .svc_hi (svc_hi),
        .pick   (pick)
    );

    int_call_seq #(
        .POLL_STATE  (POLL_STATE),
        .LAST_STATE  (LAST_STATE),
        .CALL_CYCLES (CALL_CYCLES)
    ) i_call (
        .clk        (clk),
        .rst        (rst),
        .slot       (slot),
        .pick       (pick),
        .insn_last  (insn_last),
        .insn_block (insn_block),
        .ext_edge   (ext_edge),
        .hw_clr     (hw_clr),
        .call_req   (call_req),
        .call_src   (call_src_e),
        .call_hi    (call_hi)
    );

    assign req_flags = flags;
    assign call_src  = call_src_e;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!call_req && req_flags == '0)); // R12

endmodule

// File: tb/test_int_sample_seq.sv
module test_int_sample_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cyc_state = 3'd1;
    logic       cyc_phase = 1'b0;
    logic [1:0] ext_n = 2'b11;
    logic [1:0] ext_edge = 2'b00;
    logic       tmr0_ovf = 0, tmr1_ovf = 0, ser_rx_set = 0, ser_tx_set = 0;
    logic       tmr2_ovf = 0, tmr2_ext = 0;
    logic [5:0] src_en = 6'h3F, src_hi = 6'h00;
    logic       svc_lo = 0, svc_hi = 0, insn_last = 1, insn_block = 0;
    logic [7:0] sw_clr = 8'h00;
    logic [7:0] req_flags;
    logic       call_req, call_hi;
    logic [2:0] call_src;

    always #5 clk = ~clk;

    int_sample_seq i_int_sample_seq (
        .clk(clk), .rst(rst), .cyc_state(cyc_state), .cyc_phase(cyc_phase),
        .ext_n(ext_n), .ext_edge(ext_edge), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set), .tmr2_ovf(tmr2_ovf),
        .tmr2_ext(tmr2_ext), .src_en(src_en), .src_hi(src_hi), .svc_lo(svc_lo),
        .svc_hi(svc_hi), .insn_last(insn_last), .insn_block(insn_block),
        .sw_clr(sw_clr), .req_flags(req_flags), .call_req(call_req),
        .call_src(call_src), .call_hi(call_hi)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R12";

    // stimulus phase position
    int cur_st = 1, cur_ph = 0;
    // one-shot pulse: bits t0,t1,rx,tx,t2ovf,t2ext
    bit [5:0] arm_vec = 0;
    int arm_st = 0, arm_ph = 0;
    bit [7:0] clr_req = 0;

    // reference model state
    bit [7:0] mflag = 0;
    bit [1:0] mprev = 2'b11;
    bit macc = 0, mcall = 0, mhi = 0, acc_hi = 0;
    int mleft = 0, msrc = 0, acc_src = 0;

    task automatic check(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_edge(int st, int ph);
        bit [7:0] old = mflag, nw;
        bit [5:0] r;
        bit found = 0;
        int fsrc = 0, fhi = 0;
        r[0] = old[0]; r[1] = old[1]; r[2] = old[2]; r[3] = old[3];
        r[4] = old[4] | old[5]; r[5] = old[6] | old[7];
        if (st == 4 && ph == 1 && !macc && !mcall && insn_last && !insn_block) begin
            for (int pass = 0; pass < 2; pass++)
                for (int s = 0; s < 6; s++)
                    if (!found && r[s] && src_en[s] && (src_hi[s] == (pass == 0)) &&
                        (pass == 0 ? !svc_hi : (!svc_hi && !svc_lo))) begin
                        found = 1; fsrc = s; fhi = (pass == 0);
                    end
        end
        nw = old & ~sw_clr;
        if (st == 5 && ph == 1) begin
            for (int k = 0; k < 2; k++) begin
                if (ext_edge[k]) begin
                    if (mprev[k] && !ext_n[k]) nw[2*k] = 1;
                end else nw[2*k] = !ext_n[k];
            end
            mprev = ext_n;
            nw[1] |= tmr0_ovf; nw[3] |= tmr1_ovf; nw[4] |= ser_rx_set;
            nw[5] |= ser_tx_set; nw[7] |= tmr2_ext;
        end
        if (st == 2 && ph == 1) nw[6] |= tmr2_ovf;
        if (st == 6 && ph == 1) begin
            if (macc) begin
                mcall = 1; mleft = 1; msrc = acc_src; mhi = acc_hi; macc = 0;
                if (acc_src == 0 && ext_edge[0]) nw[0] = 0;
                if (acc_src == 1) nw[1] = 0;
                if (acc_src == 2 && ext_edge[1]) nw[2] = 0;
                if (acc_src == 3) nw[3] = 0;
            end else if (mcall) begin
                if (mleft == 0) mcall = 0; else mleft--;
            end
        end
        if (found) begin macc = 1; acc_src = fsrc; acc_hi = fhi; end
        mflag = nw;
    endtask

    task automatic step();
        @(negedge clk);
        check(req_flags == mflag, "req_flags", req_flags, mflag);
        check(call_req == mcall, "call_req", call_req, mcall);
        if (mcall) begin
            check(call_src == msrc[2:0], "call_src", call_src, msrc);
            check(call_hi == mhi, "call_hi", call_hi, mhi);
        end
        cyc_state = cur_st[2:0];
        cyc_phase = cur_ph[0];
        {tmr2_ext, tmr2_ovf, ser_tx_set, ser_rx_set, tmr1_ovf, tmr0_ovf} = 6'b0;
        if (arm_vec != 0 && cur_st == arm_st && cur_ph == arm_ph) begin
            {tmr2_ext, tmr2_ovf, ser_tx_set, ser_rx_set, tmr1_ovf, tmr0_ovf} = arm_vec;
            arm_vec = 0;
        end
        sw_clr = 8'h00;
        if (cur_st == 1 && cur_ph == 0) begin sw_clr = clr_req; clr_req = 0; end
        @(posedge clk);
        model_edge(cur_st, cur_ph);
        #1;
        if (cur_ph == 1) begin cur_ph = 0; cur_st = (cur_st == 6) ? 1 : cur_st + 1; end
        else cur_ph = 1;
    endtask

    task automatic mcyc(int n);
        for (int i = 0; i < 12 * n; i++) step();
    endtask

    task automatic arm(bit [5:0] v, int st, int ph);
        arm_vec = v; arm_st = st; arm_ph = ph;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200_000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 0;
        @(negedge clk);
        // R12: reset state seen at the ports
        check(req_flags == 8'h00, "reset flags R12", req_flags, 0);
        check(call_req == 1'b0, "reset call_req R12", call_req, 0);
        mcyc(2);

        // R1: level-mode pin, one machine cycle low
        cur_req = "R1";
        ext_n = 2'b10; mcyc(1); ext_n = 2'b11; mcyc(5);

        // R2 / R9: edge mode, pin held low, one call, flag cleared by hardware
        cur_req = "R2";
        ext_edge = 2'b11; ext_n = 2'b01; mcyc(4); ext_n = 2'b11; mcyc(2);
        cur_req = "R9";
        check(req_flags[2] == 1'b0, "edge flag cleared", req_flags[2], 0);

        // R3: pulses outside the latch point are ignored
        cur_req = "R3";
        arm(6'b000001, 3, 0); mcyc(2);
        arm(6'b010000, 5, 1); mcyc(2);
        arm(6'b100000, 2, 1); mcyc(2);
        check(req_flags == 8'h00, "misplaced pulses", req_flags, 0);

        // R4: tmr0 waits a cycle, tmr2 overflow polled in its own cycle
        cur_req = "R4";
        arm(6'b000001, 5, 1); mcyc(5);
        arm(6'b010000, 2, 1); mcyc(5);
        // R9: tmr2 flag kept by hardware, R10: software clear
        cur_req = "R10";
        clr_req = 8'h40; mcyc(4);
        check(req_flags[6] == 1'b0, "sw clear tmr2", req_flags[6], 0);

        // R5: several sources pending at one poll
        cur_req = "R5";
        insn_last = 0; ext_edge = 2'b01; src_hi = 6'b001000;
        ext_n = 2'b10; mcyc(1); ext_n = 2'b11;
        arm(6'b000111, 5, 1); mcyc(2);
        insn_last = 1; mcyc(14);
        clr_req = 8'h10; mcyc(4);

        // R6: final-cycle and blocking-instruction gating
        cur_req = "R6";
        insn_last = 0; arm(6'b000001, 5, 1); mcyc(4);
        insn_last = 1; insn_block = 1; mcyc(3);
        insn_block = 0; mcyc(4);

        // R7: in-service levels
        cur_req = "R7";
        src_hi = 6'b000010; svc_hi = 1;
        arm(6'b000011, 5, 1); mcyc(4);
        svc_hi = 0; svc_lo = 1; mcyc(6);
        svc_lo = 0; mcyc(5);

        // R8: plain call span
        cur_req = "R8";
        src_hi = 6'b000000;
        arm(6'b000100, 5, 1); mcyc(5);
        clr_req = 8'h10; mcyc(3);

        // R11: disabled source keeps its flag and is never called
        cur_req = "R11";
        src_en = 6'b111101; arm(6'b000001, 5, 1); mcyc(5);
        check(req_flags[1] == 1'b1, "disabled flag kept", req_flags[1], 1);
        src_en = 6'h3F; mcyc(5);

        finish_run();
    end

endmodule